// File: doc/BRIEF.md
# Delay-Chain Assertion Monitor

This block is a synthesizable checker for a clocked implication that links a trigger to a later outcome. In delay mode the obligation is that `value` is high exactly `LEN` cycles after a cycle in which `trig` was high. In repeat mode the obligation is that `held` stays high in the trigger cycle and in each of the `LEN - 1` cycles after it, and that `value` is high in the cycle after that run, `LEN` cycles after the trigger. The block reports each attempt's outcome as a single-cycle `fail` or `pass` pulse.

Every attempt in flight is one bit in a chain of `LEN` registered stages. A bit at chain index k marks an attempt that started k+1 cycles earlier. The chain is cut into chunks of at most `CHUNK_W` bits (never more than 64). Each chunk shifts once per clock, and the top bit of one chunk feeds bit 0 of the next. Attempts may overlap freely, one per cycle. The `dis` input works like a disable condition: any cycle in which it is high cancels every attempt whose window contains that cycle.

Top module: `delay_chain_monitor`

## Requirements
- R1: A synchronous active-high `rst` empties the whole chain. After reset is released, neither output pulses until an attempt started after reset reaches its verdict.
- R2: In delay mode, a trigger in cycle t gives exactly one pulse in cycle t+LEN. That pulse is `pass` if `value` is high in t+LEN and `fail` if it is low. No other cycle carries a pulse for that attempt.
- R3: Triggers in consecutive or closely spaced cycles are tracked as independent attempts. Each attempt reaches its own verdict in its own cycle.
- R4: The chain is split into chunks of at most `CHUNK_W` bits, with `CHUNK_W` no greater than 64. An attempt moves from the top bit of one chunk into bit 0 of the next chunk with no lost or extra cycle. With `LEN` = 130 and `CHUNK_W` = 64 (three chunks), the verdict lands on exactly cycle t+130.
- R5: The stimulus can hold `value` high only in cycle t+130 after each trigger. Against that stimulus, monitors with `LEN` of 129 and 131 report `fail` for every attempt that is not cancelled.
- R6: If `dis` is high in any single cycle from t to t+LEN, the attempt started in t is cancelled and reports neither `fail` nor `pass`. This includes a `dis` pulse in the trigger cycle or in the verdict cycle.
- R7: If `dis` is held high across a whole window, that window's attempt is suppressed.
- R8: In repeat mode, `held` must be high in cycles t through t+LEN-1, and `value` is then judged in t+LEN. If `held` is low in a cycle t+k with k < LEN, `fail` pulses in that cycle and the attempt ends.
- R9: In repeat mode, a stimulus may hold `held` high for exactly six cycles from each trigger. Against that stimulus, a monitor with `LEN` = 7 reports `fail` for every attempt that is not cancelled.
- R10: In delay mode, the `held` input has no effect on the chain or on either output.
- R11: A trigger that arrives in a cycle where `dis` is high starts no attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the chain |
| trig | input | 1 | Starts an attempt in the cycle it is high |
| held | input | 1 | Repeated condition that every step needs in repeat mode; ignored in delay mode |
| value | input | 1 | Outcome that is judged in the verdict cycle |
| dis | input | 1 | Cancels every attempt in flight and masks both outputs in the same cycle |
| fail | output | 1 | One-cycle pulse when an attempt fails |
| pass | output | 1 | One-cycle pulse when an attempt succeeds |

## Verification
The embedded properties check, on every cycle, the rules that can be stated locally. Reset and `dis` empty the chain. No pulse appears while `dis` is high. In delay mode the chain advances by exactly one stage regardless of `held`. An attempt crosses each chunk boundary in one step, and a dropped `held` in repeat mode produces a failure. The full timing relation between a trigger and its verdict is `LEN` cycles long, so only the bench's scenarios can show it. Those scenarios cover the landing on cycle 130 across three chunks, the failures of the 129 and 131 stage neighbours, a single `dis` pulse in the middle or at the end of a window compared with `dis` held for a whole window, and dense overlapping triggers. In each of these the monitor's pulses are compared with a history-based model on every cycle.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic {
        MODE_DELAY  = 1'b0,
        MODE_REPEAT = 1'b1
    } chain_mode_e;

    localparam int MAX_CHUNK_W = 64;

    typedef struct packed {
        logic fail;
        logic pass;
    } verdict_t;

    function automatic int chunk_count(input int len, input int cw);
        return (len + cw - 1) / cw;
    endfunction

    function automatic int chunk_width(input int len, input int cw, input int idx);
        int rem;
        rem = len - idx * cw;
        return (rem < cw) ? rem : cw;
    endfunction

endpackage

// File: rtl/dcm_chunk.sv
module dcm_chunk #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         feed,
    input  logic         step,
    input  logic         keep,
    output logic [W-1:0] bits,
    output logic         top
);

    logic [W-1:0] vec_q;

    // One masked shift: the step gates only the moved bits, keep wipes all.
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            vec_q <= (((vec_q << 1) & {W{step}}) | W'(feed)) & {W{keep}};
        end
    end

    assign bits = vec_q;
    assign top  = vec_q[W-1];

    // R6: a cancelled cycle leaves nothing behind in this chunk
    assert_chunk_cancel_R6: assert property (@(posedge clk) disable iff (rst)
        !keep |=> (bits == '0));

    // R4: an accepted feed always lands in bit 0
    assert_chunk_feed_R4: assert property (@(posedge clk) disable iff (rst)
        (feed && keep) |=> bits[0]);

endmodule

// File: rtl/dcm_verdict.sv
module dcm_verdict
    import dcm_pkg::*;
#(
    parameter int          LEN  = 130,
    parameter chain_mode_e MODE = MODE_DELAY
) (
    input  logic [LEN-1:0] chain,
    input  logic           trig,
    input  logic           held,
    input  logic           value,
    input  logic           dis,
    output verdict_t       verdict
);

    logic final_bit;
    logic mid_live;
    logic drop;

    assign final_bit = chain[LEN-1];
    assign mid_live  = |chain[LEN-2:0];

    generate
        if (MODE == MODE_REPEAT) begin : g_rep
            assign drop = !held && (trig || mid_live);
        end else begin : g_dly
            assign drop = 1'b0;
        end
    endgenerate

    always_comb begin
        verdict.fail = !dis && ((final_bit && !value) || drop);
        verdict.pass = !dis && final_bit && value;
    end

endmodule

// File: rtl/delay_chain_monitor.sv
module delay_chain_monitor
    import dcm_pkg::*;
#(
    parameter int          LEN     = 130,
    parameter int          CHUNK_W = 64,
    parameter chain_mode_e MODE    = MODE_DELAY
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic held,
    input  logic value,
    input  logic dis,
    output logic fail,
    output logic pass
);

    localparam int NCHUNK = chunk_count(LEN, CHUNK_W);

    logic              step;
    logic              keep;
    logic [LEN-1:0]    chain;
    logic [NCHUNK-1:0] tops;
    verdict_t          vd;

    generate
        if (LEN < 2 || CHUNK_W < 1 || CHUNK_W > MAX_CHUNK_W) begin : g_bad_cfg
            $error("delay_chain_monitor: LEN must be >= 2 and CHUNK_W within 1..64");
        end
        if (MODE == MODE_REPEAT) begin : g_step_rep
            assign step = held;
        end else begin : g_step_dly
            assign step = 1'b1;
        end
    endgenerate

    assign keep = !dis;

    for (genvar i = 0; i < NCHUNK; i++) begin : g_chunk
        localparam int W    = chunk_width(LEN, CHUNK_W, i);
        localparam int BASE = i * CHUNK_W;
        logic feed;
        if (i == 0) begin : g_head
            assign feed = trig && step;
        end else begin : g_link
            assign feed = tops[i-1] && step;
            // R4: an attempt crosses a chunk boundary in exactly one cycle
            assert_chunk_carry_R4: assert property (@(posedge clk) disable iff (rst)
                (chain[BASE-1] && step && !dis) |=> chain[BASE]);
        end
        dcm_chunk #(.W(W)) u_chunk (
            .clk  (clk),
            .rst  (rst),
            .feed (feed),
            .step (step),
            .keep (keep),
            .bits (chain[BASE +: W]),
            .top  (tops[i])
        );
    end

    dcm_verdict #(.LEN(LEN), .MODE(MODE)) u_verdict (
        .chain   (chain),
        .trig    (trig),
        .held    (held),
        .value   (value),
        .dis     (dis),
        .verdict (vd)
    );

    assign fail = vd.fail;
    assign pass = vd.pass;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (chain == '0));

    assert_quiet_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        dis |-> !(fail || pass));

    generate
        if (MODE == MODE_DELAY) begin : g_dly_chk
            assert_shift_ignores_held_R10: assert property (@(posedge clk) disable iff (rst)
                !dis |=> (chain[LEN-1:1] == $past(chain[LEN-2:0])));
            assert_single_outcome_R2: assert property (@(posedge clk) disable iff (rst)
                !(fail && pass));
        end else begin : g_rep_chk
            assert_repeat_drop_fails_R8: assert property (@(posedge clk) disable iff (rst)
                (!dis && !held && (|chain[LEN-2:0])) |-> fail);
        end
    endgenerate

endmodule

// File: tb/sim_delay_chain_monitor.sv
`timescale 1ns/1ps
module sim_delay_chain_monitor;
    import dcm_pkg::*;

    localparam int MAXC = 2048;
    localparam int NI   = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, trig = 1'b0, held = 1'b0, value = 1'b0, dis = 1'b0;
    logic [NI-1:0] fl, ps;

    // u0: 130 stages over three chunks; u1/u2: neighbours 129 and 131;
    // u3/u4: repeat mode with 6 and 7 steps over 4-bit chunks.
    delay_chain_monitor #(.LEN(130), .CHUNK_W(64), .MODE(MODE_DELAY)) u0 (
        .clk(clk), .rst(rst), .trig(trig), .held(held), .value(value), .dis(dis),
        .fail(fl[0]), .pass(ps[0]));
    delay_chain_monitor #(.LEN(129), .CHUNK_W(64), .MODE(MODE_DELAY)) u1 (
        .clk(clk), .rst(rst), .trig(trig), .held(held), .value(value), .dis(dis),
        .fail(fl[1]), .pass(ps[1]));
    delay_chain_monitor #(.LEN(131), .CHUNK_W(64), .MODE(MODE_DELAY)) u2 (
        .clk(clk), .rst(rst), .trig(trig), .held(held), .value(value), .dis(dis),
        .fail(fl[2]), .pass(ps[2]));
    delay_chain_monitor #(.LEN(6), .CHUNK_W(4), .MODE(MODE_REPEAT)) u3 (
        .clk(clk), .rst(rst), .trig(trig), .held(held), .value(value), .dis(dis),
        .fail(fl[3]), .pass(ps[3]));
    delay_chain_monitor #(.LEN(7), .CHUNK_W(4), .MODE(MODE_REPEAT)) u4 (
        .clk(clk), .rst(rst), .trig(trig), .held(held), .value(value), .dis(dis),
        .fail(fl[4]), .pass(ps[4]));

    bit trig_h [MAXC];
    bit held_h [MAXC];
    bit value_h[MAXC];
    bit kill_h [MAXC];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lfsr = 32'h1ACE;
    bit seg1 = 1'b0;
    bit seg2 = 1'b0;
    int nf[NI];
    int np[NI];
    int dl[NI] = '{130, 129, 131, 6, 7};
    bit rp[NI] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    // Behavioural model: looks back over the input history for attempts.
    function automatic void model(input int d, input bit rep, input int c,
                                  output bit ef, output bit ep);
        bit alive;
        int age;
        ef = 1'b0;
        ep = 1'b0;
        if (kill_h[c]) return;
        for (int s = c - d; s <= c; s++) begin
            if (s < 0) continue;
            if (!trig_h[s]) continue;
            age = c - s;
            alive = 1'b1;
            for (int k = s; k <= c; k++) if (kill_h[k]) alive = 1'b0;
            if (rep) for (int k = s; k < c; k++) if (!held_h[k]) alive = 1'b0;
            if (!alive) continue;
            if (age == d) begin
                if (value_h[c]) ep = 1'b1; else ef = 1'b1;
            end else if (rep && !held_h[c]) begin
                ef = 1'b1;
            end
        end
    endfunction

    function automatic string req_of(input int i);
        if (cyc < 8) return "R1";
        if (dis) return "R6";
        if (seg2) return "R3";
        case (i)
            0: return "R4";
            1, 2: return "R5";
            3: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic bit rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr[7];
    endfunction

    task automatic drive(input bit r, input bit t, input bit h, input bit v, input bit d);
        bit ef, ep;
        @(negedge clk);
        rst = r; trig = t; held = h; value = v; dis = d;
        trig_h[cyc] = t; held_h[cyc] = h; value_h[cyc] = v; kill_h[cyc] = d | r;
        #1;
        if (!r) begin
            for (int i = 0; i < NI; i++) begin
                model(dl[i], rp[i], cyc, ef, ep);
                checks++;
                if (fl[i] !== ef || ps[i] !== ep) begin
                    errors++;
                    $display("FAIL %s u%0d cycle %0d: fail=%b pass=%b expected fail=%b pass=%b",
                             req_of(i), i, cyc, fl[i], ps[i], ef, ep);
                end
                if (seg1) begin
                    nf[i] += int'(fl[i]);
                    np[i] += int'(ps[i]);
                end
            end
        end
        cyc++;
    endtask

    task automatic chk_count(input string r, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", r, what, got, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok, d, h, v;
        for (int i = 0; i < NI; i++) begin nf[i] = 0; np[i] = 0; end
        // R1: reset, then quiet cycles
        for (int k = 0; k < 3; k++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // Directed segment: one attempt every 140 cycles.
        // k=1: single dis pulse mid-window (R6); k=3: dis held all window,
        // trigger included (R7, R11); k=4: failing attempt cancelled by a dis
        // pulse in its verdict cycle (R6). Held is random after p=6 (R10).
        seg1 = 1'b1;
        for (int k = 0; k < 8; k++) begin
            ok = !(k == 2 || k == 4 || k == 5);
            for (int p = 0; p < 140; p++) begin
                d = (k == 1 && p == 65) || (k == 3 && p <= 130) || (k == 4 && p == 130);
                h = (p < 6) ? 1'b1 : ((p == 6) ? 1'b0 : rnd());
                v = (p == 6) || (p == 130 && ok);
                drive(1'b0, p == 0, h, v, d);
            end
        end
        seg1 = 1'b0;
        chk_count("R4", "u0 passes landing on cycle 130", np[0], 3);
        chk_count("R2", "u0 failures", nf[0], 2);
        chk_count("R10", "u0 passes with random held", np[0] + nf[0], 5);
        chk_count("R5", "u1 (129) failures", nf[1], 6);
        chk_count("R5", "u2 (131) failures", nf[2], 5);
        chk_count("R5", "u1/u2 passes", np[1] + np[2], 0);
        chk_count("R7", "u3 passes with held window suppressed", np[3], 7);
        chk_count("R9", "u4 failures", nf[4], 7);
        chk_count("R9", "u4 passes", np[4], 0);
        // Dense overlapping attempts (R3)
        seg2 = 1'b1;
        for (int k = 0; k < 400; k++) begin
            d = rnd() && rnd() && rnd() && rnd() && rnd();
            h = rnd() || rnd() || rnd();
            v = rnd() || rnd();
            drive(1'b0, rnd(), h, v, d);
        end
        for (int k = 0; k < 200; k++) drive(1'b0, 1'b0, rnd(), rnd(), 1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule